// File: doc/BRIEF.md
# Queued Command Sequencer for a Storage Device

This block is the command-layer controller of a storage device that supports native command queuing. It accepts up to 2^TAG_W queued read and write commands. Each command is named by a tag, and the block records the tag in an outstanding-tag bitmap. After each command is accepted, a good register frame tells the host that the interface is free again. An external scheduler picks which outstanding tag moves to its data phase. The block then issues the DMA-setup request and, where needed, the DMA-activate request. When the transfer finishes it reports completion with a set-device-bits request.

The block also watches for host protocol faults. These are a queued command that reuses an outstanding tag, or a non-queued command while any tag is outstanding. It also takes transfer errors from the data path. After any of these it answers every command with an error frame until a log-read command arrives. It then drops the whole queue and reports an all-ones active mask. A soft reset returns it to idle from any state.

Commands enter on a valid/ready stream. `cmd_ready` is high only in idle and in wait-for-clear. Outgoing frame requests leave on a second valid/ready stream. While `frm_valid` is high and `frm_ready` is low, every frame field holds steady, the state holds, and neither input stream is accepted. Data-phase requests from the scheduler use a third valid/ready pair. That pair is ready only in idle and only when no command is being offered, so commands win.

Top module: `ncq_ctrl`

## Requirements
- R1: After reset, `active_mask` is 0, `frm_valid` is 0, `recovering` is 0, and `cmd_ready` and `dp_ready` are 1.
- R2: In idle, a queued command (kind 0 = read, kind 1 = write) whose tag is not outstanding sets that tag's bit in `active_mask`. It then yields one register frame (type 0) with `frm_err`=0, and the block returns to idle.
- R3: A queued command whose tag is already outstanding yields a register frame with `frm_err`=1 (type 1). The block then enters wait-for-clear (`recovering`=1) and leaves `active_mask` unchanged.
- R4: A non-queued command (kind 2) yields the error frame of R3 and enters wait-for-clear when any tag is outstanding. It yields a good register frame (type 0) when no tag is outstanding.
- R5: An accepted data-phase request for an outstanding read tag yields a DMA-setup frame (type 2) carrying that tag, with `frm_dir`=1 (host memory write) and `frm_aa`=0. A data-phase request for a tag that is not outstanding is accepted and ignored, and no frame follows.
- R6: For an outstanding write tag with `aa_en`=1, the DMA-setup frame has `frm_dir`=0 and `frm_aa`=1. No activate frame follows, and the block waits for the transfer.
- R7: For an outstanding write tag with `aa_en`=0, the DMA-setup frame has `frm_aa`=0 and `frm_dir`=0. It is followed by a DMA-activate frame (type 3) with the same tag.
- R8: `xfer_done` during a transfer clears the tag's bit. It then yields a set-device-bits frame (type 4) with the tag, `frm_err`=0, `frm_irq`=1, and `frm_active` equal to the bitmap after the clear. The block returns to idle.
- R9: `xfer_err` during a transfer yields a set-device-bits frame with `frm_err`=1, `frm_irq`=1, and `frm_active` equal to the unchanged bitmap. The block then enters wait-for-clear.
- R10: In wait-for-clear, any command other than log-read is answered with an error register frame (type 1). The bitmap stays unchanged, the block stays in wait-for-clear, and `dp_ready` is 0.
- R11: A log-read command (kind 3) in wait-for-clear clears the bitmap. It yields a set-device-bits frame with `frm_active` all ones, `frm_err`=0 and `frm_irq`=0, and the block returns to idle.
- R12: `soft_rst` high at a clock edge, in any state, clears the bitmap, drops any pending frame, and returns the block to idle.
- R13: While `frm_valid`=1 and `frm_ready`=0, all frame fields and `frm_valid` hold steady, and `cmd_ready` and `dp_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset from the host |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_kind | input | 2 | 0 queued read, 1 queued write, 2 non-queued, 3 log-read |
| cmd_tag | input | TAG_W | Tag of a queued command |
| dp_valid | input | 1 | Scheduler offers a tag for its data phase |
| dp_ready | output | 1 | Data-phase request can be taken |
| dp_tag | input | TAG_W | Tag chosen by the scheduler |
| aa_en | input | 1 | Auto-activate supported and enabled |
| xfer_done | input | 1 | Data path finished the current transfer |
| xfer_err | input | 1 | Data path hit an unrecoverable error |
| frm_valid | output | 1 | Frame request pending |
| frm_ready | input | 1 | Frame request taken by the transport |
| frm_type | output | 3 | 0 good register, 1 error register, 2 DMA setup, 3 DMA activate, 4 set-device-bits |
| frm_tag | output | TAG_W | Tag carried by the frame |
| frm_dir | output | 1 | DMA-setup direction, 1 = host memory write |
| frm_aa | output | 1 | DMA-setup auto-activate flag |
| frm_err | output | 1 | Error flag of the frame |
| frm_irq | output | 1 | Interrupt flag of a set-device-bits frame |
| frm_active | output | 2^TAG_W | Active mask of a set-device-bits frame |
| active_mask | output | 2^TAG_W | Outstanding-tag bitmap |
| recovering | output | 1 | Block is in wait-for-clear |

## Verification
Queued commands with fresh tags are sent first, then repeated with a reused tag. This separates a working duplicate check from one that never fires or always fires. A non-queued command is sent both with an empty queue and with a busy queue, which shows the mixed-command rule depends on the bitmap. Writes are run with auto-activate on and off, and reads are run too. Together these tell apart the three setup variants and whether an activate frame follows. Completions with other tags still pending show that only the finished tag's bit is cleared. Transfer errors, rejected commands in recovery, log-read, a stale data-phase tag, back-pressure on frames and a soft reset during a pending frame cover the recovery path and the handshake rules.

// File: rtl/ncq_pkg.sv
package ncq_pkg;
  typedef enum logic [1:0] {
    K_QREAD  = 2'd0,
    K_QWRITE = 2'd1,
    K_PLAIN  = 2'd2,
    K_LOGRD  = 2'd3
  } kind_t;

  typedef enum logic [2:0] {
    F_REG_OK    = 3'd0,
    F_REG_ERR   = 3'd1,
    F_DMA_SETUP = 3'd2,
    F_DMA_ACT   = 3'd3,
    F_SDB       = 3'd4
  } frame_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACK,
    S_BROKEN,
    S_WAITCLR,
    S_REJECT,
    S_SETUP,
    S_ACTIV,
    S_XFER,
    S_SDB_DONE,
    S_SDB_ERR,
    S_SDB_CLEAN
  } state_t;
endpackage

// File: rtl/ncq_tagmap.sv
module ncq_tagmap #(
  parameter int TAG_W = 5,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             set_wr,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [TAG_W-1:0] look_a,
  output logic             hit_a,
  input  logic [TAG_W-1:0] look_b,
  output logic             hit_b,
  output logic             wr_b,
  output logic             any_busy,
  output logic [NTAG-1:0]  q_mask
);
  logic [NTAG-1:0] wr_slot;

  for (genvar g = 0; g < NTAG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_mask[g]  <= 1'b0;
        wr_slot[g] <= 1'b0;
      end else if (wipe) begin
        q_mask[g] <= 1'b0;
      end else if (set_en && set_tag == TAG_W'(g)) begin
        q_mask[g]  <= 1'b1;
        wr_slot[g] <= set_wr;
      end else if (clr_en && clr_tag == TAG_W'(g)) begin
        q_mask[g] <= 1'b0;
      end
    end
  end

  assign hit_a    = q_mask[look_a];
  assign hit_b    = q_mask[look_b];
  assign wr_b     = wr_slot[look_b];
  assign any_busy = |q_mask;

  p_set_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !wipe && !clr_en |=> q_mask[$past(set_tag)]);
  p_wipe_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> q_mask == '0);
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !set_en |=> !q_mask[$past(clr_tag)]);
endmodule

// File: rtl/ncq_seq.sv
module ncq_seq
  import ncq_pkg::*;
#(
  parameter int TAG_W = 5,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_kind,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             dp_valid,
  output logic             dp_ready,
  input  logic [TAG_W-1:0] dp_tag,
  input  logic             aa_en,
  input  logic             xfer_done,
  input  logic             xfer_err,
  input  logic             hit_cmd,
  input  logic             hit_dp,
  input  logic             wr_dp,
  input  logic             any_busy,
  input  logic [NTAG-1:0]  q_mask,
  output logic             wipe,
  output logic             set_en,
  output logic             set_wr,
  output logic             clr_en,
  output logic [TAG_W-1:0] clr_tag,
  output logic             frm_valid,
  input  logic             frm_ready,
  output logic [2:0]       frm_type,
  output logic [TAG_W-1:0] frm_tag,
  output logic             frm_dir,
  output logic             frm_aa,
  output logic             frm_err,
  output logic             frm_irq,
  output logic [NTAG-1:0]  frm_active,
  output logic             recovering
);
  state_t st, nxt;
  logic [TAG_W-1:0] cur_tag;
  logic cur_wr, cur_aa;
  logic cmd_fire, dp_fire, is_queued;
  kind_t kind;

  assign kind      = kind_t'(cmd_kind);
  assign is_queued = (kind == K_QREAD) || (kind == K_QWRITE);
  assign cmd_ready = (st == S_IDLE) || (st == S_WAITCLR);
  assign dp_ready  = (st == S_IDLE) && !cmd_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign dp_fire   = dp_valid && dp_ready;
  assign set_wr    = (kind == K_QWRITE);
  assign clr_tag   = cur_tag;

  always_comb begin
    nxt    = st;
    set_en = 1'b0;
    clr_en = 1'b0;
    wipe   = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (cmd_fire) begin
          if (is_queued) begin
            if (hit_cmd) nxt = S_BROKEN;
            else begin
              set_en = 1'b1;
              nxt    = S_ACK;
            end
          end else begin
            nxt = any_busy ? S_BROKEN : S_ACK;
          end
        end else if (dp_fire && hit_dp) begin
          nxt = S_SETUP;
        end
      end
      S_WAITCLR: begin
        if (cmd_fire) begin
          if (kind == K_LOGRD) begin
            wipe = 1'b1;
            nxt  = S_SDB_CLEAN;
          end else begin
            nxt = S_REJECT;
          end
        end
      end
      S_XFER: begin
        if (xfer_err) nxt = S_SDB_ERR;
        else if (xfer_done) begin
          clr_en = 1'b1;
          nxt    = S_SDB_DONE;
        end
      end
      S_ACK, S_SDB_DONE, S_SDB_CLEAN: if (frm_ready) nxt = S_IDLE;
      S_BROKEN, S_REJECT, S_SDB_ERR:  if (frm_ready) nxt = S_WAITCLR;
      S_SETUP:  if (frm_ready) nxt = (cur_wr && !cur_aa) ? S_ACTIV : S_XFER;
      S_ACTIV:  if (frm_ready) nxt = S_XFER;
      default:  nxt = S_IDLE;
    endcase
    if (soft_rst) begin
      nxt    = S_IDLE;
      wipe   = 1'b1;
      set_en = 1'b0;
      clr_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_tag <= '0;
      cur_wr  <= 1'b0;
      cur_aa  <= 1'b0;
    end else begin
      st <= nxt;
      if (!soft_rst && st == S_IDLE) begin
        if (cmd_fire) cur_tag <= cmd_tag;
        else if (dp_fire) begin
          cur_tag <= dp_tag;
          cur_wr  <= wr_dp;
          cur_aa  <= aa_en;
        end
      end
    end
  end

  always_comb begin
    frm_valid  = 1'b1;
    frm_type   = F_REG_OK;
    frm_err    = 1'b0;
    frm_irq    = 1'b0;
    frm_active = '0;
    unique case (st)
      S_ACK:       frm_type = F_REG_OK;
      S_BROKEN,
      S_REJECT: begin
        frm_type = F_REG_ERR;
        frm_err  = 1'b1;
      end
      S_SETUP:     frm_type = F_DMA_SETUP;
      S_ACTIV:     frm_type = F_DMA_ACT;
      S_SDB_DONE: begin
        frm_type   = F_SDB;
        frm_irq    = 1'b1;
        frm_active = q_mask;
      end
      S_SDB_ERR: begin
        frm_type   = F_SDB;
        frm_irq    = 1'b1;
        frm_err    = 1'b1;
        frm_active = q_mask;
      end
      S_SDB_CLEAN: begin
        frm_type   = F_SDB;
        frm_active = '1;
      end
      default:     frm_valid = 1'b0;
    endcase
  end

  assign frm_tag    = cur_tag;
  assign frm_dir    = (st == S_SETUP) && !cur_wr;
  assign frm_aa     = (st == S_SETUP) && cur_wr && cur_aa;
  assign recovering = (st == S_WAITCLR);

  p_frame_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready && !soft_rst |=>
      frm_valid && $stable(frm_type) && $stable(frm_tag) && $stable(frm_dir)
      && $stable(frm_aa) && $stable(frm_err) && $stable(frm_irq));
  p_no_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> !cmd_ready && !dp_ready);
  p_dup_errors_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && cmd_fire && is_queued && hit_cmd && !soft_rst |=>
      frm_valid && frm_type == F_REG_ERR);
  p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !frm_valid && cmd_ready);
  p_clean_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAITCLR && cmd_fire && kind == K_LOGRD && !soft_rst |=>
      frm_valid && (&frm_active) && !frm_err && !frm_irq);
endmodule

// File: rtl/ncq_ctrl.sv
module ncq_ctrl #(
  parameter int TAG_W = 5,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_kind,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             dp_valid,
  output logic             dp_ready,
  input  logic [TAG_W-1:0] dp_tag,
  input  logic             aa_en,
  input  logic             xfer_done,
  input  logic             xfer_err,
  output logic             frm_valid,
  input  logic             frm_ready,
  output logic [2:0]       frm_type,
  output logic [TAG_W-1:0] frm_tag,
  output logic             frm_dir,
  output logic             frm_aa,
  output logic             frm_err,
  output logic             frm_irq,
  output logic [NTAG-1:0]  frm_active,
  output logic [NTAG-1:0]  active_mask,
  output logic             recovering
);
  logic wipe, set_en, set_wr, clr_en;
  logic [TAG_W-1:0] clr_tag;
  logic hit_cmd, hit_dp, wr_dp, any_busy;

  ncq_tagmap #(.TAG_W(TAG_W)) u_map (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .set_en(set_en), .set_tag(cmd_tag), .set_wr(set_wr),
    .clr_en(clr_en), .clr_tag(clr_tag),
    .look_a(cmd_tag), .hit_a(hit_cmd),
    .look_b(dp_tag), .hit_b(hit_dp), .wr_b(wr_dp),
    .any_busy(any_busy), .q_mask(active_mask)
  );

  ncq_seq #(.TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_tag(cmd_tag),
    .dp_valid(dp_valid), .dp_ready(dp_ready), .dp_tag(dp_tag),
    .aa_en(aa_en), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .hit_cmd(hit_cmd), .hit_dp(hit_dp), .wr_dp(wr_dp),
    .any_busy(any_busy), .q_mask(active_mask),
    .wipe(wipe), .set_en(set_en), .set_wr(set_wr),
    .clr_en(clr_en), .clr_tag(clr_tag),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_type(frm_type),
    .frm_tag(frm_tag), .frm_dir(frm_dir), .frm_aa(frm_aa),
    .frm_err(frm_err), .frm_irq(frm_irq), .frm_active(frm_active),
    .recovering(recovering)
  );
endmodule

// File: tb/test_ncq_ctrl.sv
module test_ncq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 5;
  localparam int NTAG = 1 << TAG_W;

  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic cmd_valid = 0, dp_valid = 0, aa_en = 0, xfer_done = 0, xfer_err = 0;
  logic frm_ready = 1;
  logic [1:0] cmd_kind = 0;
  logic [TAG_W-1:0] cmd_tag = 0, dp_tag = 0;
  logic cmd_ready, dp_ready, frm_valid, frm_dir, frm_aa, frm_err, frm_irq, recovering;
  logic [2:0] frm_type;
  logic [TAG_W-1:0] frm_tag;
  logic [NTAG-1:0] frm_active, active_mask;

  int n_chk = 0, n_bad = 0;
  logic [2:0] g_type;
  logic [TAG_W-1:0] g_tag;
  logic g_dir, g_aa, g_err, g_irq, g_seen;
  logic [NTAG-1:0] g_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  ncq_ctrl #(.TAG_W(TAG_W)) i_ncq_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_tag(cmd_tag),
    .dp_valid(dp_valid), .dp_ready(dp_ready), .dp_tag(dp_tag), .aa_en(aa_en),
    .xfer_done(xfer_done), .xfer_err(xfer_err),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_type(frm_type), .frm_tag(frm_tag),
    .frm_dir(frm_dir), .frm_aa(frm_aa), .frm_err(frm_err), .frm_irq(frm_irq),
    .frm_active(frm_active), .active_mask(active_mask), .recovering(recovering)
  );

  function automatic logic [NTAG-1:0] bit_of(input int t);
    logic [NTAG-1:0] v = '0;
    v[t] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] k, input int t);
    @(negedge clk);
    cmd_valid = 1; cmd_kind = k; cmd_tag = TAG_W'(t);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic send_dp(input int t);
    @(negedge clk);
    dp_valid = 1; dp_tag = TAG_W'(t);
    while (!dp_ready) @(negedge clk);
    @(posedge clk); #1;
    dp_valid = 0;
  endtask

  task automatic get_frame();
    int n = 0;
    g_seen = 0;
    while (!frm_valid && n < 20) begin @(negedge clk); n++; end
    if (frm_valid) begin
      g_seen = 1;
      g_type = frm_type; g_tag = frm_tag; g_dir = frm_dir; g_aa = frm_aa;
      g_err = frm_err; g_irq = frm_irq; g_act = frm_active;
      while (!frm_ready) @(negedge clk);
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_done(input logic err);
    @(negedge clk);
    if (err) xfer_err = 1; else xfer_done = 1;
    @(negedge clk);
    xfer_err = 0; xfer_done = 0;
  endtask

  task automatic t_reset();
    chk("R1", "mask", 64'(active_mask), 0);
    chk("R1", "frm_valid", 64'(frm_valid), 0);
    chk("R1", "recovering", 64'(recovering), 0);
    chk("R1", "readies", {62'd0, cmd_ready, dp_ready}, 3);
  endtask

  task automatic t_queue_ok();
    send_cmd(2'd0, 3); get_frame();
    chk("R2", "seen", 64'(g_seen), 1);
    chk("R2", "type", 64'(g_type), 0);
    chk("R2", "err", 64'(g_err), 0);
    send_cmd(2'd1, 7); get_frame();
    chk("R2", "type", 64'(g_type), 0);
    chk("R2", "mask", 64'(active_mask), 64'(bit_of(3) | bit_of(7)));
    chk("R2", "back idle", {63'd0, cmd_ready}, 1);
  endtask

  task automatic t_read_phase();
    send_dp(3); get_frame();
    chk("R5", "type", 64'(g_type), 2);
    chk("R5", "tag", 64'(g_tag), 3);
    chk("R5", "dir/aa", {62'd0, g_dir, g_aa}, 2);
    pulse_done(0); get_frame();
    chk("R8", "type", 64'(g_type), 4);
    chk("R8", "tag", 64'(g_tag), 3);
    chk("R8", "err/irq", {62'd0, g_err, g_irq}, 1);
    chk("R8", "active", 64'(g_act), 64'(bit_of(7)));
    chk("R8", "mask", 64'(active_mask), 64'(bit_of(7)));
  endtask

  task automatic t_write_aa();
    aa_en = 1;
    send_dp(7); get_frame();
    chk("R6", "type", 64'(g_type), 2);
    chk("R6", "dir/aa", {62'd0, g_dir, g_aa}, 1);
    @(negedge clk); @(negedge clk);
    chk("R6", "no activate", 64'(frm_valid), 0);
    pulse_done(0); get_frame();
    chk("R8", "active empty", 64'(g_act), 0);
    aa_en = 0;
  endtask

  task automatic t_write_noaa();
    send_cmd(2'd1, 9); get_frame();
    send_dp(9); get_frame();
    chk("R7", "setup aa", {61'd0, g_type, g_aa}, 64'h4);
    chk("R7", "dir", 64'(g_dir), 0);
    get_frame();
    chk("R7", "activate type", 64'(g_type), 3);
    chk("R7", "activate tag", 64'(g_tag), 9);
    pulse_done(0); get_frame();
    chk("R8", "tag", 64'(g_tag), 9);
    chk("R8", "mask", 64'(active_mask), 0);
  endtask

  task automatic t_stale_dp();
    send_dp(12);
    @(negedge clk); @(negedge clk);
    chk("R5", "stale no frame", 64'(frm_valid), 0);
    chk("R5", "stale still idle", {62'd0, cmd_ready, dp_ready}, 3);
  endtask

  task automatic t_plain_empty();
    send_cmd(2'd2, 0); get_frame();
    chk("R4", "empty good", 64'(g_type), 0);
    chk("R4", "not recovering", 64'(recovering), 0);
  endtask

  task automatic t_dup_and_reject();
    send_cmd(2'd0, 5); get_frame();
    send_cmd(2'd1, 5); get_frame();
    chk("R3", "type", 64'(g_type), 1);
    chk("R3", "err", 64'(g_err), 1);
    chk("R3", "recovering", 64'(recovering), 1);
    chk("R3", "mask", 64'(active_mask), 64'(bit_of(5)));
    send_cmd(2'd0, 6); get_frame();
    chk("R10", "reject type", 64'(g_type), 1);
    chk("R10", "mask kept", 64'(active_mask), 64'(bit_of(5)));
    chk("R10", "still recovering", 64'(recovering), 1);
    chk("R10", "dp blocked", 64'(dp_ready), 0);
    send_cmd(2'd3, 0); get_frame();
    chk("R11", "type", 64'(g_type), 4);
    chk("R11", "active ones", 64'(g_act), 64'({NTAG{1'b1}}));
    chk("R11", "err/irq", {62'd0, g_err, g_irq}, 0);
    chk("R11", "mask", 64'(active_mask), 0);
    chk("R11", "idle", 64'(recovering), 0);
  endtask

  task automatic t_mixed();
    send_cmd(2'd0, 1); get_frame();
    send_cmd(2'd2, 0); get_frame();
    chk("R4", "busy rejects", 64'(g_type), 1);
    chk("R4", "recovering", 64'(recovering), 1);
    send_cmd(2'd3, 0); get_frame();
    chk("R11", "mask", 64'(active_mask), 0);
  endtask

  task automatic t_xfer_err();
    send_cmd(2'd0, 2); get_frame();
    send_cmd(2'd1, 4); get_frame();
    send_dp(2); get_frame();
    pulse_done(1); get_frame();
    chk("R9", "type", 64'(g_type), 4);
    chk("R9", "err/irq", {62'd0, g_err, g_irq}, 3);
    chk("R9", "active", 64'(g_act), 64'(bit_of(2) | bit_of(4)));
    chk("R9", "recovering", 64'(recovering), 1);
    send_cmd(2'd3, 0); get_frame();
  endtask

  task automatic t_backpressure();
    frm_ready = 0;
    send_cmd(2'd0, 8);
    @(negedge clk);
    chk("R13", "valid held", 64'(frm_valid), 1);
    @(negedge clk); @(negedge clk);
    chk("R13", "still valid", 64'(frm_valid), 1);
    chk("R13", "type stable", 64'(frm_type), 0);
    chk("R13", "no accept", {62'd0, cmd_ready, dp_ready}, 0);
    frm_ready = 1;
    get_frame();
    chk("R13", "released idle", 64'(cmd_ready), 1);
  endtask

  task automatic t_soft_reset();
    frm_ready = 0;
    send_dp(8);
    @(negedge clk);
    chk("R12", "setup pending", 64'(frm_valid), 1);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    chk("R12", "frame dropped", 64'(frm_valid), 0);
    chk("R12", "mask", 64'(active_mask), 0);
    chk("R12", "idle", 64'(cmd_ready), 1);
    frm_ready = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_queue_ok();
    t_read_phase();
    t_write_aa();
    t_write_noaa();
    t_stale_dp();
    t_plain_empty();
    t_dup_and_reject();
    t_mixed();
    t_xfer_err();
    t_backpressure();
    t_soft_reset();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule